// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external processor reach a 64-entry register file of 8-bit registers over a four-wire synchronous serial link. The link has an active-low select (`cs_n`), a shift clock (`sk`), serial data in (`si`) and serial data out (`so`). The slave runs on its own system clock. It samples the serial pins through a synchronizer and finds the shift-clock edges itself.

Every group of eight shift clocks is one byte cycle. While a byte shifts in, the result of the previous byte shifts out, so all responses come back one byte late. The first byte after select is a command: two operation bits followed by a register address. The operation can be a read, a no-op, a single write or a burst write. A write command is followed by one data byte, or by a stream of data bytes that all go to one address until select is released.

On the register side the slave drives an address, a write strobe with write data, and a read strobe. The read strobe marks a read that may carry side effects, such as clear-on-read. The register file returns its data combinationally for the address driven. The slave also samples that data without the read strobe when it needs a quiet read-back.

Top module: `mwire_regslave`

## Requirements
- R1: After reset, `so` is 0 and neither `reg_we` nor `reg_re` is asserted.
- R2: `si` is sampled on rising `sk` edges, most significant bit first. In a command byte, bits 7:6 hold the operation (00 read, 01 no-op, 10 single write, 11 burst write) and bits 5:0 hold the register address.
- R3: A read command shifts the addressed register out on `so`, most significant bit first, during the next byte cycle. `so` only moves after falling `sk` edges. `reg_re` pulses for exactly one clock per read command.
- R4: During a command byte, `so` carries the result of the previous read or write, even when that command byte is itself a read.
- R5: A no-op command makes the next byte cycle repeat the previous result, and it never asserts `reg_re`.
- R6: For a single write, the data byte that follows the command is written once to the commanded address, after the eighth falling `sk` of that byte. The byte after it is decoded as a command again.
- R7: After any write, the next byte cycle shifts out the register value as read back after the write. That read-back never asserts `reg_re`.
- R8: In burst write, every byte after the command is written to the same address until `cs_n` rises. After reselect, the first byte is again a command.
- R9: If `cs_n` rises partway through a byte, that partial byte is dropped with no register access, and the next byte after reselect is a command. While `cs_n` is high, `so` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sk | input | 1 | Serial shift clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| reg_addr | output | 6 | Register file address |
| reg_we | output | 1 | Register write strobe, one clock |
| reg_wdata | output | 8 | Register write data |
| reg_re | output | 1 | Read strobe with side effects, one clock |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
A bit counter that drifts out of step shows up as a skewed byte on `so` in the very next byte cycle. It also decodes a data byte as a command, which produces an unexpected write or read strobe within that byte. A wrong command or data state is caught no later than the next select window: a burst that outlives its select writes to the address of a later command, and a leftover partial byte turns the following read into garbage.

A read-back that fires the side-effect strobe shows directly as a count of `reg_re` pulses. It also shows a cycle later as a cleared clear-on-read register.

// File: rtl/mwire_pkg.sv
package mwire_pkg;
   typedef enum logic [1:0] {
      CMD_READ  = 2'b00,
      CMD_NOP   = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_BURST = 2'b11
   } mw_cmd_e;

   typedef enum logic {
      ST_CMD  = 1'b0,
      ST_DATA = 1'b1
   } mw_state_e;
endpackage

// File: rtl/mwire_sync.sv
module mwire_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sk,
   input  logic si,
   output logic cs_act,
   output logic sk_rise,
   output logic sk_fall,
   output logic si_s
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] cs_q, sk_q, si_q;
   logic              sk_prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_q[0] <= 1'b1;
               sk_q[0] <= 1'b0;
               si_q[0] <= 1'b0;
            end else begin
               cs_q[0] <= cs_n;
               sk_q[0] <= sk;
               si_q[0] <= si;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_q[i] <= 1'b1;
               sk_q[i] <= 1'b0;
               si_q[i] <= 1'b0;
            end else begin
               cs_q[i] <= cs_q[i-1];
               sk_q[i] <= sk_q[i-1];
               si_q[i] <= si_q[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_prev <= 1'b0;
      else        sk_prev <= sk_q[LAST];
   end

   assign cs_act  = ~cs_q[LAST];
   assign sk_rise = sk_q[LAST] & ~sk_prev;
   assign sk_fall = ~sk_q[LAST] & sk_prev;
   assign si_s    = si_q[LAST];

   initial begin
      assert (STAGES >= 2) else $error("mwire_sync: STAGES must be at least 2");
   end
endmodule

// File: rtl/mwire_shift.sv
module mwire_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sk_rise,
   input  logic              sk_fall,
   input  logic              si_s,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] rx_byte,
   output logic              byte_done,
   output logic              tx_msb
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_q, tx_q;

   assign byte_done = cs_act && sk_fall && (cnt == FULL);
   assign rx_byte   = rx_q;
   assign tx_msb    = tx_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         rx_q <= '0;
      end else if (!cs_act) begin
         cnt <= '0;
      end else begin
         if (sk_rise && cnt != FULL) begin
            rx_q <= {rx_q[DATA_W-2:0], si_s};
            cnt  <= cnt + 1'b1;
         end else if (sk_fall && cnt == FULL) begin
            cnt <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (load) begin
         tx_q <= load_val;
      end else if (cs_act && sk_fall && cnt != '0 && cnt != FULL) begin
         tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
   end

   // R2: the bit counter never exceeds one byte
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);

   // R9: deselect always returns the counter to the start of a byte
   assert_deselect_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> cnt == '0);

   initial begin
      assert (DATA_W >= 2) else $error("mwire_shift: DATA_W too small");
   end
endmodule

// File: rtl/mwire_ctrl.sv
module mwire_ctrl
   import mwire_pkg::*;
#(
   parameter int CMD_W  = 2,
   parameter int ADDR_W = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_act,
   input  logic                      byte_done,
   input  logic [CMD_W+ADDR_W-1:0]   rx_byte,
   input  logic [CMD_W+ADDR_W-1:0]   reg_rdata,
   output logic [ADDR_W-1:0]         reg_addr,
   output logic                      reg_we,
   output logic [CMD_W+ADDR_W-1:0]   reg_wdata,
   output logic                      reg_re,
   output logic                      load,
   output logic [CMD_W+ADDR_W-1:0]   load_val
);
   localparam int DATA_W = CMD_W + ADDR_W;

   mw_state_e           state;
   mw_cmd_e             cmd;
   logic                burst;
   logic [ADDR_W-1:0]   addr_q;
   logic                we_q, rd_pend, wb_pend, load_q;
   logic [DATA_W-1:0]   wdata_q, last_res, load_val_q;

   assign cmd       = mw_cmd_e'(rx_byte[DATA_W-1 -: CMD_W]);
   assign reg_addr  = addr_q;
   assign reg_we    = we_q;
   assign reg_wdata = wdata_q;
   assign reg_re    = rd_pend;
   assign load      = load_q;
   assign load_val  = load_val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_CMD;
         burst      <= 1'b0;
         addr_q     <= '0;
         we_q       <= 1'b0;
         wdata_q    <= '0;
         rd_pend    <= 1'b0;
         wb_pend    <= 1'b0;
         last_res   <= '0;
         load_q     <= 1'b0;
         load_val_q <= '0;
      end else begin
         we_q    <= 1'b0;
         load_q  <= 1'b0;
         wb_pend <= we_q;
         if (rd_pend || wb_pend) begin
            last_res   <= reg_rdata;
            load_q     <= 1'b1;
            load_val_q <= reg_rdata;
            rd_pend    <= 1'b0;
         end
         if (!cs_act) begin
            state <= ST_CMD;
            burst <= 1'b0;
            if (!(rd_pend || wb_pend)) begin
               load_q     <= 1'b1;
               load_val_q <= last_res;
            end
         end else if (byte_done) begin
            if (state == ST_CMD) begin
               unique case (cmd)
                  CMD_READ: begin
                     addr_q  <= rx_byte[ADDR_W-1:0];
                     rd_pend <= 1'b1;
                  end
                  CMD_NOP: begin
                     load_q     <= 1'b1;
                     load_val_q <= last_res;
                  end
                  CMD_WRITE, CMD_BURST: begin
                     addr_q     <= rx_byte[ADDR_W-1:0];
                     burst      <= (cmd == CMD_BURST);
                     state      <= ST_DATA;
                     load_q     <= 1'b1;
                     load_val_q <= last_res;
                  end
                  default: ;
               endcase
            end else begin
               we_q    <= 1'b1;
               wdata_q <= rx_byte;
               if (!burst) state <= ST_CMD;
            end
         end
      end
   end

   // R3: a side-effect read strobe lasts a single clock
   assert_re_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R5: a no-op command never produces a side-effect read
   assert_nop_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && byte_done && state == ST_CMD && cmd == CMD_NOP) |=> !reg_re);

   // R6: each data byte causes one single-clock write
   assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R7: the post-write read-back never raises the side-effect strobe
   assert_wb_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_pend |-> !reg_re);

   // R8: the address does not move while a write is issued
   assert_burst_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $stable(reg_addr));

   initial begin
      assert (CMD_W == 2) else $error("mwire_ctrl: CMD_W must be 2");
      assert (ADDR_W >= 1) else $error("mwire_ctrl: ADDR_W must be positive");
   end
endmodule

// File: rtl/mwire_regslave.sv
module mwire_regslave #(
   parameter int CMD_W       = 2,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    sk,
   input  logic                    si,
   output logic                    so,
   output logic [ADDR_W-1:0]       reg_addr,
   output logic                    reg_we,
   output logic [CMD_W+ADDR_W-1:0] reg_wdata,
   output logic                    reg_re,
   input  logic [CMD_W+ADDR_W-1:0] reg_rdata
);
   localparam int DATA_W = CMD_W + ADDR_W;

   logic              cs_act, sk_rise, sk_fall, si_s;
   logic              byte_done, tx_msb, load;
   logic [DATA_W-1:0] rx_byte, load_val;

   mwire_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .sk      (sk),
      .si      (si),
      .cs_act  (cs_act),
      .sk_rise (sk_rise),
      .sk_fall (sk_fall),
      .si_s    (si_s)
   );

   mwire_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .sk_rise   (sk_rise),
      .sk_fall   (sk_fall),
      .si_s      (si_s),
      .load      (load),
      .load_val  (load_val),
      .rx_byte   (rx_byte),
      .byte_done (byte_done),
      .tx_msb    (tx_msb)
   );

   mwire_ctrl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .reg_rdata (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_re    (reg_re),
      .load      (load),
      .load_val  (load_val)
   );

   assign so = cs_act & tx_msb;

   // R6: no write and side-effect read in the same clock
   assert_we_re_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
endmodule

// File: tb/mwire_regslave_test.sv
module mwire_regslave_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sk = 1'b0, si = 1'b0;
   logic       so, reg_we, reg_re;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [7:0] mem [64];
   int         checks = 0, errors = 0, re_cnt = 0, we_cnt = 0;

   always #10 clk = ~clk;

   mwire_regslave uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sk(sk), .si(si), .so(so),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_re(reg_re), .reg_rdata(reg_rdata)
   );

   // register file model: 62 keeps only its low nibble, 63 clears on read
   assign reg_rdata = mem[reg_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 3 + 1);
      end else if (reg_we) begin
         mem[reg_addr] <= (reg_addr == 6'd62) ? (reg_wdata & 8'h0F) : reg_wdata;
         we_cnt <= we_cnt + 1;
      end else if (reg_re) begin
         if (reg_addr == 6'd63) mem[63] <= 8'h00;
         re_cnt <= re_cnt + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic sel();
      cs_n = 1'b0;
      wait_clk(8);
   endtask

   task automatic desel();
      cs_n = 1'b1;
      wait_clk(16);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         si = tx[i];
         wait_clk(8);
         rx[i] = so;
         sk = 1'b1;
         wait_clk(8);
         sk = 1'b0;
      end
      wait_clk(16);
   endtask

   task automatic t_reset();
      logic [7:0] r;
      wait_clk(4);
      check("R1 so after reset", so, 0);
      check("R1 strobes after reset", we_cnt + re_cnt, 0);
      r = 8'h00;
      check("R1 no activity", r, 0);
   endtask

   task automatic t_read();
      logic [7:0] r;
      int re0;
      re0 = re_cnt;
      sel();
      xfer(8'h05, r);                 // read addr 5
      xfer(8'h07, r);                 // read addr 7 while returning addr 5
      check("R3 read data addr5", r, 16);
      check("R4 result during read command", r, 16);
      xfer(8'h40, r);                 // no-op
      check("R2 read data addr7", r, 22);
      check("R3 one strobe per read", re_cnt - re0, 2);
      xfer(8'h40, r);                 // no-op again
      check("R5 nop repeats result", r, 22);
      check("R5 nop no strobe", re_cnt - re0, 2);
      desel();
      check("R9 so idle when deselected", so, 0);
   endtask

   task automatic t_clear();
      logic [7:0] r;
      sel();
      xfer(8'h3F, r);
      xfer(8'h40, r);
      check("R3 clear-on-read first value", r, 190);
      xfer(8'h3F, r);
      xfer(8'h40, r);
      check("R3 cleared by genuine read", r, 0);
      desel();
   endtask

   task automatic t_write();
      logic [7:0] r;
      int we0, re0;
      we0 = we_cnt; re0 = re_cnt;
      sel();
      xfer(8'h8A, r);                 // write addr 10
      xfer(8'hA5, r);
      check("R6 single write count", we_cnt - we0, 1);
      check("R6 written value", mem[10], 8'hA5);
      xfer(8'h40, r);
      check("R7 readback after write", r, 8'hA5);
      xfer(8'hBE, r);                 // write addr 62 (masked)
      xfer(8'hFF, r);
      xfer(8'h40, r);
      check("R7 post-write value", r, 8'h0F);
      check("R7 readback no strobe", re_cnt - re0, 0);
      check("R6 command after data byte", we_cnt - we0, 2);
      desel();
   endtask

   task automatic t_burst();
      logic [7:0] r;
      int we0;
      we0 = we_cnt;
      sel();
      xfer(8'hD4, r);                 // burst addr 20
      xfer(8'h01, r);
      xfer(8'h02, r);
      check("R8 burst readback 1", r, 1);
      xfer(8'h03, r);
      check("R8 burst readback 2", r, 2);
      desel();
      check("R8 burst write count", we_cnt - we0, 3);
      check("R8 final value", mem[20], 3);
      check("R8 neighbour untouched", mem[21], 64);
      sel();
      xfer(8'h14, r);                 // read addr 20, must not be written
      check("R8 result kept across deselect", r, 3);
      xfer(8'h40, r);
      check("R8 reselect starts with command", r, 3);
      check("R8 no write after reselect", we_cnt - we0, 3);
      desel();
   endtask

   task automatic t_abort();
      logic [7:0] r;
      int we0, re0;
      we0 = we_cnt; re0 = re_cnt;
      sel();
      for (int i = 0; i < 3; i++) begin
         si = (i != 1);
         wait_clk(8);
         sk = 1'b1;
         wait_clk(8);
         sk = 1'b0;
      end
      wait_clk(8);
      desel();
      check("R9 partial byte no access", (we_cnt - we0) + (re_cnt - re0), 0);
      sel();
      xfer(8'h05, r);
      xfer(8'h40, r);
      check("R9 command after abort", r, 16);
      check("R9 no write from partial", we_cnt - we0, 0);
      desel();
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      t_reset();
      t_read();
      t_clear();
      t_write();
      t_burst();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule